// File: doc/BRIEF.md
# Counting Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and presents them to a parent processor on two lines, a normal interrupt line and a fast interrupt line. It detects transitions on each source and keeps a latched level bit per source. It also keeps two enable masks: one for the normal line and one for the fast line. It maintains a running count of the sources that are both latched and enabled for the normal line.

Software reaches the block through a simple register bus with a byte offset inside a 4 KB window. It reads the live pending count and the number of the lowest pending source. It turns a single source on or off by writing that source's number, rather than a bit mask. It can wipe all latched levels with one write, and it loads the fast-line mask as a whole word. An access that the register map does not define leaves the state untouched and raises a sticky error flag.

Top module: `cnt_intc`

## Requirements
- R1: After reset the latched levels, both enable masks, the pending count and the error flag are zero, so `irq_o`, `fiq_o` and `bus_err` are low.
- R2: A low-to-high change on `src_in[i]` sets level bit i on the next clock edge. The pending count rises by one at that edge if source i is enabled for the normal line. An input that stays high changes nothing.
- R3: A high-to-low change on `src_in[i]` clears level bit i on the next clock edge. The pending count falls by one at that edge if source i is enabled for the normal line.
- R4: A read at offset 0x00 returns the pending count, which always equals the number of sources that are both latched and enabled for the normal line.
- R5: A read at offset 0x04 returns the smallest index that is both latched and enabled for the normal line, or 0 when there is none.
- R6: A write at offset 0x10 enables the source whose number is in `bus_wdata[4:0]`; the upper data bits are ignored. If that source is latched, the count rises by one. Enabling a source that is already enabled has no effect.
- R7: A write at offset 0x0C disables the numbered source (same index field as R6). If that source is latched, the count falls by one. Disabling a source that is already disabled has no effect.
- R8: A write at offset 0x08 clears every level bit and zeroes the count, and leaves both enable masks unchanged. A source held high stays unlatched until it falls and rises again.
- R9: `irq_o` is high exactly when some source is both latched and enabled for the normal line. `fiq_o` is high exactly when some source is both latched and set in the fast-line mask.
- R10: Offset 0x14 holds the 32-bit fast-line mask, which can be read and written.
- R11: A read at any offset other than 0x00, 0x04 or 0x14, or a write at any offset other than 0x08, 0x0C, 0x10 or 0x14, sets the sticky `bus_err` and has no other effect. Such a read returns 0.
- R12: A source edge and an enable or disable write to the same source in one cycle both take effect, and the count remains consistent as stated in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Level inputs from the interrupt sources |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while `bus_rd` is high |
| irq_o | output | 1 | Normal interrupt line to the parent processor |
| fiq_o | output | 1 | Fast interrupt line to the parent processor |
| bus_err | output | 1 | Sticky flag for undefined accesses |

## Verification
The bench builds the block with its defaults: 32 sources and a 12-bit offset. This makes the full 5-bit index field live, so an index written with stray upper bits (37 selecting source 5) can be checked. Sources far apart in the vector (3, 7, 20) can also be checked against the lowest-index search. With this configuration the bench can reach count changes from edges, from enable writes and from disable writes, including a write and an edge that meet on one source in the same cycle. It can also reach the case where a wipe leaves a source that is still held high unlatched.

// File: rtl/cnt_intc.sv
module cnt_intc #(
  parameter int NSRC = 32,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_o,
  output logic            fiq_o,
  output logic            bus_err
);
  localparam int IW = $clog2(NSRC);
  localparam int CW = $clog2(NSRC + 1);
  localparam logic [AW-1:0] A_CNT  = AW'('h00);
  localparam logic [AW-1:0] A_NUM  = AW'('h04);
  localparam logic [AW-1:0] A_WIPE = AW'('h08);
  localparam logic [AW-1:0] A_OFF  = AW'('h0C);
  localparam logic [AW-1:0] A_ON   = AW'('h10);
  localparam logic [AW-1:0] A_FMSK = AW'('h14);

  logic [NSRC-1:0] src_q, level, irq_en, fiq_en;
  logic [CW-1:0]   count;

  function automatic logic [CW-1:0] pop(input logic [NSRC-1:0] v);
    pop = '0;
    for (int i = 0; i < NSRC; i++) pop = pop + CW'(v[i]);
  endfunction

  wire [NSRC-1:0] rise = src_in & ~src_q;
  wire [NSRC-1:0] fall = ~src_in & src_q;

  wire wipe_w = bus_wr && bus_addr == A_WIPE;
  wire off_w  = bus_wr && bus_addr == A_OFF;
  wire on_w   = bus_wr && bus_addr == A_ON;
  wire fmsk_w = bus_wr && bus_addr == A_FMSK;
  wire wr_bad = bus_wr && !(wipe_w || off_w || on_w || fmsk_w);
  wire rd_bad = bus_rd && !(bus_addr == A_CNT || bus_addr == A_NUM || bus_addr == A_FMSK);

  wire [IW-1:0]   idx = bus_wdata[IW-1:0];
  wire [NSRC-1:0] sel = NSRC'(1) << idx;

  wire [NSRC-1:0] lvl_base = wipe_w ? '0 : level;
  wire [NSRC-1:0] lvl_n    = (lvl_base | rise) & ~fall;
  wire [NSRC-1:0] en_n     = (irq_en | (on_w ? sel : '0)) & ~(off_w ? sel : '0);
  wire [NSRC-1:0] p_cur    = lvl_base & irq_en;
  wire [NSRC-1:0] p_nxt    = lvl_n & en_n;
  wire [CW-1:0]   cnt_base = wipe_w ? '0 : count;
  wire [CW-1:0]   cnt_n    = cnt_base + pop(p_nxt & ~p_cur) - pop(p_cur & ~p_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      level   <= '0;
      irq_en  <= '0;
      fiq_en  <= '0;
      count   <= '0;
      bus_err <= 1'b0;
    end else begin
      src_q  <= src_in;
      level  <= lvl_n;
      irq_en <= en_n;
      count  <= cnt_n;
      if (fmsk_w) fiq_en <= bus_wdata[NSRC-1:0];
      if (wr_bad || rd_bad) bus_err <= 1'b1;
    end
  end

  wire [NSRC-1:0] pend = level & irq_en;
  logic [IW-1:0] low_idx;
  always_comb begin
    low_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) low_idx = IW'(i);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CNT:   bus_rdata = 32'(count);
        A_NUM:   bus_rdata = 32'(low_idx);
        A_FMSK:  bus_rdata = 32'(fiq_en);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq_o = |pend;
  assign fiq_o = |(level & fiq_en);

  p_count_consistent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count == CW'($countones(level & irq_en)));

  p_irq_matches_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (count != '0));

  p_wipe_zeroes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_w && rise == '0 |=> count == '0 && level == '0);

  p_wipe_keeps_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_w |=> $stable(irq_en) && $stable(fiq_en));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> bus_err);

  p_bad_access_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bad || !bus_wr) && rise == '0 && fall == '0 |=> $stable(level) && $stable(irq_en) && $stable(fiq_en) && $stable(count));

  p_steady_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr && rise == '0 && fall == '0 |=> $stable(count));
endmodule

// File: tb/cnt_intc_tb.sv
module cnt_intc_tb;
  localparam int TCLK = 10;
  localparam int NSRC = 32;
  localparam int AW   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_in = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o, fiq_o, bus_err;
  int n_chk = 0, n_bad = 0;

  always #(TCLK/2) clk = ~clk;

  cnt_intc #(.NSRC(NSRC), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .bus_err(bus_err));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic drive_src(input logic [NSRC-1:0] v);
    @(negedge clk);
    src_in = v;
    @(negedge clk);
  endtask

  task automatic expect_cnt(input string req, input int c);
    logic [31:0] d;
    rd('h00, d);
    check(req, d, 32'(c));
  endtask

  task automatic expect_num(input string req, input int n);
    logic [31:0] d;
    rd('h04, d);
    check(req, d, 32'(n));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 fiq", {31'b0, fiq_o}, 0);
    check("R1 err", {31'b0, bus_err}, 0);
    expect_cnt("R1 count", 0);
    rd('h14, d);
    check("R1 fast mask", d, 0);
  endtask

  task automatic t_edges;
    wr('h10, 3);
    wr('h10, 7);
    expect_cnt("R6 enable idle sources", 0);
    drive_src(32'h0000_0080);
    expect_cnt("R2 rise enabled", 1);
    check("R9 irq on", {31'b0, irq_o}, 1);
    expect_num("R5 single", 7);
    drive_src(32'h0010_0088);
    expect_cnt("R2 rise with one disabled", 2);
    expect_num("R5 lowest", 3);
    drive_src(32'h0010_0088);
    expect_cnt("R2 steady high", 2);
    drive_src(32'h0010_0080);
    expect_cnt("R3 fall enabled", 1);
    expect_num("R5 after fall", 7);
  endtask

  task automatic t_enable;
    wr('h10, 20);
    expect_cnt("R6 enable latched", 2);
    wr('h10, 20);
    expect_cnt("R6 enable twice", 2);
    wr('h0C, 7);
    expect_cnt("R7 disable latched", 1);
    expect_num("R7 number moves", 20);
    wr('h0C, 7);
    expect_cnt("R7 disable twice", 1);
    wr('h10, 37);
    expect_cnt("R6 upper bits ignored", 1);
    drive_src(32'h0010_00A0);
    expect_cnt("R6 index 5 enabled", 2);
    expect_num("R5 index 5", 5);
  endtask

  task automatic t_fast;
    logic [31:0] d;
    check("R9 fiq off", {31'b0, fiq_o}, 0);
    wr('h14, 32'h0010_0000);
    rd('h14, d);
    check("R10 mask readback", d, 32'h0010_0000);
    check("R9 fiq on", {31'b0, fiq_o}, 1);
  endtask

  task automatic t_wipe;
    logic [31:0] d;
    wr('h08, 0);
    expect_cnt("R8 count zero", 0);
    check("R8 irq low", {31'b0, irq_o}, 0);
    check("R8 fiq low", {31'b0, fiq_o}, 0);
    rd('h14, d);
    check("R8 fast mask kept", d, 32'h0010_0000);
    drive_src(32'h0010_00A0);
    expect_cnt("R8 held high stays clear", 0);
    drive_src('0);
    drive_src(32'h0010_0000);
    expect_cnt("R8 enable kept", 1);
    check("R9 fiq after re-rise", {31'b0, fiq_o}, 1);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    src_in = 32'h0010_0200;
    bus_wr = 1'b1; bus_addr = 'h10; bus_wdata = 9;
    @(negedge clk);
    bus_wr = 1'b0;
    expect_cnt("R12 rise with enable", 2);
    @(negedge clk);
    src_in = 32'h0010_0000;
    bus_wr = 1'b1; bus_addr = 'h0C; bus_wdata = 9;
    @(negedge clk);
    bus_wr = 1'b0;
    expect_cnt("R12 fall with disable", 1);
  endtask

  task automatic t_errors;
    logic [31:0] d;
    check("R11 no error yet", {31'b0, bus_err}, 0);
    rd('h08, d);
    check("R11 write-only read data", d, 0);
    check("R11 flag set", {31'b0, bus_err}, 1);
    rd('h40, d);
    check("R11 unmapped read data", d, 0);
    wr('h04, 3);
    wr('h02, 20);
    expect_cnt("R11 count untouched", 1);
    rd('h14, d);
    check("R11 fast mask untouched", d, 32'h0010_0000);
    check("R11 sticky", {31'b0, bus_err}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edges();
    t_enable();
    t_fast();
    t_wipe();
    t_same_cycle();
    t_errors();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(TCLK * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule